// File: doc/BRIEF.md
# Dual-Issue Hazard Checker

This block is the issue-control stage of a two-wide, strictly in-order pipeline. Each cycle it is offered an older and a younger decoded instruction. Each offer carries a valid bit, a destination register, two source registers and a functional-unit index. The older slot also carries a branch flag. The block also sees which units are busy and whether a branch issued earlier is still unresolved. It answers within the same cycle: how many of the two offers may leave (0, 1 or 2) and, when something was held back, a code naming the hazard that held it.

Internally it keeps a pending-write bit for every architectural register. A bit is raised when an instruction writing that register issues. It is dropped when the writeback port names the register. Register 0 reads as zero and never takes part in a dependency. A younger-slot branch has no in-cycle effect: once it has issued, the surrounding pipeline reports it through `br_pending`.

Top module: `hz_dual_issue_checker`

## Requirements
- R1: Reset (synchronous, `rst_n` low at a rising edge) clears every pending-write bit, so no register stays blocked after reset.
- R2: `issue_cnt` is 0 when slot 0 is invalid or stalled, 1 when slot 0 issues and slot 1 is invalid or stalled, and 2 only when both slots are valid and clean. Slot 1 never issues without slot 0, even when slot 1 has no hazard.
- R3: Flow hazard. A nonzero source register of a slot that is pending, or that equals the valid older slot's destination in the same cycle, stalls that slot.
- R4: Output hazard. A nonzero destination of a slot that is pending, or that equals the older slot's destination in the same cycle, stalls that slot.
- R5: Anti hazard. A nonzero destination of slot 1 that equals either source of slot 0 stalls slot 1.
- R6: Resource hazard. A slot stalls when `unit_busy[unit]` is 1, and slot 1 also stalls when its unit index equals slot 0's.
- R7: Procedural hazard. While `br_pending` is 1 no slot issues. When slot 0 has its branch flag set, slot 1 stalls in that cycle.
- R8: Pending bits change only at the clock edge. A bit is set for each issued slot with a nonzero destination and cleared for `wb_reg` when `wb_valid` is 1. If both hit the same register in one cycle, the bit ends set. A writeback is visible from the next cycle on.
- R9: Register 0 never causes a hazard as a source or as a destination, and it is never marked pending.
- R10: `stall_why` reports the first stalled slot in program order: 0 none, 1 procedural, 2 resource, 3 flow, 4 output, 5 anti. Within one slot, the lowest nonzero code wins. It is 0 when slot 0 is invalid or when every valid slot issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_dst | input | 5 | Older slot destination register (0 = none) |
| s0_src_a | input | 5 | Older slot first source register |
| s0_src_b | input | 5 | Older slot second source register |
| s0_unit | input | 2 | Older slot functional-unit index |
| s0_is_br | input | 1 | Older slot is a branch |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_dst | input | 5 | Younger slot destination register |
| s1_src_a | input | 5 | Younger slot first source register |
| s1_src_b | input | 5 | Younger slot second source register |
| s1_unit | input | 2 | Younger slot functional-unit index |
| unit_busy | input | 4 | One busy bit per functional unit |
| br_pending | input | 1 | An issued branch is not yet resolved |
| wb_valid | input | 1 | Writeback retires a register this cycle |
| wb_reg | input | 5 | Register being written back |
| issue_cnt | output | 2 | Number of slots issued this cycle |
| stall_why | output | 3 | Stall reason code |

## Verification
The bench targets the same-cycle pairings between the two slots: slot 1 reading, overwriting or clobbering slot 0's registers, and sharing its unit. A design that compared only against the pending bits would let both slots issue in those cases. It checks that a clean slot 1 stays behind a stalled slot 0, which an out-of-order design would break by reporting one issue. It also checks that resource outranks flow when both apply, which a wrong priority would misreport. Further checks cover an invalid slot 0 with a valid slot 1, a writeback and an issue to the same register in one cycle (a clear-wins design would release a dependent reader too early), register 0 used everywhere, and a reset that leaves pending registers released.

// File: rtl/hz_pkg.sv
// Package: shared constants and the stall-reason encoding for the
// dual-issue hazard checker. Assumes the codes are visible outside the
// block, so their numeric values are fixed.
package hz_pkg;

    // Stall reason, lower value = higher priority among nonzero codes
    typedef enum logic [2:0] {
        WHY_NONE = 3'd0,
        WHY_PROC = 3'd1,
        WHY_RES  = 3'd2,
        WHY_FLOW = 3'd3,
        WHY_OUT  = 3'd4,
        WHY_ANTI = 3'd5
    } why_e;

endpackage

// File: rtl/hz_pending_file.sv
// Module: pending-write bit file. One bit per architectural register.
// Two set ports (one per issue slot) and one clear port (writeback).
// Assumes set has priority over clear on the same register and that
// register 0 is hardwired zero, so its bit is constant 0.
module hz_pending_file #(
    parameter int NREGS = 32,
    localparam int REG_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set0_en,
    input  logic [REG_W-1:0] set0_idx,
    input  logic             set1_en,
    input  logic [REG_W-1:0] set1_idx,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_idx,
    output logic [NREGS-1:0] pend
);

    assign pend[0] = 1'b0;

    for (genvar g = 1; g < NREGS; g++) begin : g_bit
        logic bit_q;
        logic hit_set;
        logic hit_clr;

        // Decode whether this register is touched this cycle
        always_comb begin
            hit_set = (set0_en && (set0_idx == REG_W'(g))) ||
                      (set1_en && (set1_idx == REG_W'(g)));
            hit_clr = clr_en && (clr_idx == REG_W'(g));
        end

        // Hold the pending state; a set in the same cycle beats a clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (hit_set)
                bit_q <= 1'b1;
            else if (hit_clr)
                bit_q <= 1'b0;
        end

        assign pend[g] = bit_q;
    end

endmodule

// File: rtl/hz_slot_hazard.sv
// Module: classifies the hazard of one issue slot and returns the
// highest-priority reason. With YOUNG = 1 it also compares against the
// older slot in the same cycle; with YOUNG = 0 those terms are masked.
// Assumes the older slot's fields are only meaningful when older_valid.
module hz_slot_hazard
    import hz_pkg::*;
#(
    parameter int NREGS  = 32,
    parameter int NUNITS = 4,
    parameter bit YOUNG  = 1'b0,
    localparam int REG_W  = $clog2(NREGS),
    localparam int UNIT_W = $clog2(NUNITS)
) (
    input  logic              valid,
    input  logic [REG_W-1:0]  dst,
    input  logic [REG_W-1:0]  src_a,
    input  logic [REG_W-1:0]  src_b,
    input  logic [UNIT_W-1:0] unit,
    input  logic [NREGS-1:0]  pend,
    input  logic [NUNITS-1:0] unit_busy,
    input  logic              br_pending,
    input  logic              older_valid,
    input  logic [REG_W-1:0]  older_dst,
    input  logic [REG_W-1:0]  older_src_a,
    input  logic [REG_W-1:0]  older_src_b,
    input  logic [UNIT_W-1:0] older_unit,
    input  logic              older_is_br,
    output why_e              why
);

    logic older_live;
    logic a_used, b_used, d_used;
    logic h_proc, h_res, h_flow, h_out, h_anti;

    // Qualify operands: register 0 never participates
    always_comb begin
        older_live = YOUNG && older_valid;
        a_used     = (src_a != '0);
        b_used     = (src_b != '0);
        d_used     = (dst != '0);
    end

    // Evaluate each hazard kind independently
    always_comb begin
        h_proc = br_pending || (older_live && older_is_br);
        h_res  = unit_busy[unit] || (older_live && (older_unit == unit));
        h_flow = (a_used && (pend[src_a] || (older_live && older_dst == src_a))) ||
                 (b_used && (pend[src_b] || (older_live && older_dst == src_b)));
        h_out  = d_used && (pend[dst] || (older_live && older_dst == dst));
        h_anti = d_used && older_live &&
                 ((older_src_a == dst) || (older_src_b == dst));
    end

    // Pick the reason in fixed priority order
    always_comb begin
        if (!valid)       why = WHY_NONE;
        else if (h_proc)  why = WHY_PROC;
        else if (h_res)   why = WHY_RES;
        else if (h_flow)  why = WHY_FLOW;
        else if (h_out)   why = WHY_OUT;
        else if (h_anti)  why = WHY_ANTI;
        else              why = WHY_NONE;
    end

endmodule

// File: rtl/hz_issue_select.sv
// Module: turns the two slot verdicts into an issue count and a single
// reported stall reason, enforcing in-order issue. Also produces the
// pending-file set requests for the slots that actually issue.
// Assumes slot 1 is only eligible when slot 0 issues.
module hz_issue_select
    import hz_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int REG_W = $clog2(NREGS)
) (
    input  logic             s0_valid,
    input  logic [REG_W-1:0] s0_dst,
    input  why_e             s0_why,
    input  logic             s1_valid,
    input  logic [REG_W-1:0] s1_dst,
    input  why_e             s1_why,
    output logic [1:0]       issue_cnt,
    output why_e             stall_why,
    output logic             set0_en,
    output logic             set1_en
);

    // In-order selection: the first stalled slot ends the group
    always_comb begin
        if (!s0_valid) begin
            issue_cnt = 2'd0;
            stall_why = WHY_NONE;
        end else if (s0_why != WHY_NONE) begin
            issue_cnt = 2'd0;
            stall_why = s0_why;
        end else if (!s1_valid) begin
            issue_cnt = 2'd1;
            stall_why = WHY_NONE;
        end else if (s1_why != WHY_NONE) begin
            issue_cnt = 2'd1;
            stall_why = s1_why;
        end else begin
            issue_cnt = 2'd2;
            stall_why = WHY_NONE;
        end
    end

    // Request pending marks for issued slots that write a real register
    always_comb begin
        set0_en = (issue_cnt != 2'd0) && (s0_dst != '0);
        set1_en = (issue_cnt == 2'd2) && (s1_dst != '0);
    end

endmodule

// File: rtl/hz_dual_issue_checker.sv
// Module: top of the dual-issue hazard checker. Wires two slot
// classifiers, the in-order selector and the pending-write bit file.
// Decisions are combinational on the current inputs and the registered
// pending bits; only the pending bits are state. Assumes the caller
// presents slots in program order and advances only issued slots.
module hz_dual_issue_checker
    import hz_pkg::*;
#(
    parameter int NREGS  = 32,
    parameter int NUNITS = 4,
    localparam int REG_W  = $clog2(NREGS),
    localparam int UNIT_W = $clog2(NUNITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s0_valid,
    input  logic [REG_W-1:0]  s0_dst,
    input  logic [REG_W-1:0]  s0_src_a,
    input  logic [REG_W-1:0]  s0_src_b,
    input  logic [UNIT_W-1:0] s0_unit,
    input  logic              s0_is_br,
    input  logic              s1_valid,
    input  logic [REG_W-1:0]  s1_dst,
    input  logic [REG_W-1:0]  s1_src_a,
    input  logic [REG_W-1:0]  s1_src_b,
    input  logic [UNIT_W-1:0] s1_unit,
    input  logic [NUNITS-1:0] unit_busy,
    input  logic              br_pending,
    input  logic              wb_valid,
    input  logic [REG_W-1:0]  wb_reg,
    output logic [1:0]        issue_cnt,
    output logic [2:0]        stall_why
);

    logic [NREGS-1:0] pend;
    why_e             why0, why1, why_sel;
    logic             set0_en, set1_en;

    // Older slot: checked against in-flight state only
    hz_slot_hazard #(.NREGS(NREGS), .NUNITS(NUNITS), .YOUNG(1'b0)) u_slot0 (
        .valid       (s0_valid),
        .dst         (s0_dst),
        .src_a       (s0_src_a),
        .src_b       (s0_src_b),
        .unit        (s0_unit),
        .pend        (pend),
        .unit_busy   (unit_busy),
        .br_pending  (br_pending),
        .older_valid (1'b0),
        .older_dst   ('0),
        .older_src_a ('0),
        .older_src_b ('0),
        .older_unit  ('0),
        .older_is_br (1'b0),
        .why         (why0)
    );

    // Younger slot: also checked against the older slot of this cycle
    hz_slot_hazard #(.NREGS(NREGS), .NUNITS(NUNITS), .YOUNG(1'b1)) u_slot1 (
        .valid       (s1_valid),
        .dst         (s1_dst),
        .src_a       (s1_src_a),
        .src_b       (s1_src_b),
        .unit        (s1_unit),
        .pend        (pend),
        .unit_busy   (unit_busy),
        .br_pending  (br_pending),
        .older_valid (s0_valid),
        .older_dst   (s0_dst),
        .older_src_a (s0_src_a),
        .older_src_b (s0_src_b),
        .older_unit  (s0_unit),
        .older_is_br (s0_is_br),
        .why         (why1)
    );

    hz_issue_select #(.NREGS(NREGS)) u_sel (
        .s0_valid  (s0_valid),
        .s0_dst    (s0_dst),
        .s0_why    (why0),
        .s1_valid  (s1_valid),
        .s1_dst    (s1_dst),
        .s1_why    (why1),
        .issue_cnt (issue_cnt),
        .stall_why (why_sel),
        .set0_en   (set0_en),
        .set1_en   (set1_en)
    );

    hz_pending_file #(.NREGS(NREGS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set0_en  (set0_en),
        .set0_idx (s0_dst),
        .set1_en  (set1_en),
        .set1_idx (s1_dst),
        .clr_en   (wb_valid),
        .clr_idx  (wb_reg),
        .pend     (pend)
    );

    assign stall_why = why_sel;

endmodule

// File: rtl/hz_dual_issue_sva.sv
// Module: assertion checker for hz_dual_issue_checker, attached by bind.
// Observes ports only.
module hz_dual_issue_sva #(
    parameter int NREGS  = 32,
    parameter int NUNITS = 4,
    localparam int REG_W  = $clog2(NREGS),
    localparam int UNIT_W = $clog2(NUNITS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s0_valid,
    input logic [REG_W-1:0]  s0_dst,
    input logic [REG_W-1:0]  s0_src_a,
    input logic [UNIT_W-1:0] s0_unit,
    input logic              s1_valid,
    input logic [NUNITS-1:0] unit_busy,
    input logic              br_pending,
    input logic [1:0]        issue_cnt,
    input logic [2:0]        stall_why
);

    p_cnt_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_cnt != 2'd3);

    p_young_needs_old_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == 2'd2) |-> (s0_valid && s1_valid));

    p_busy_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && unit_busy[s0_unit]) |-> (issue_cnt == 2'd0));

    p_branch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        br_pending |-> (issue_cnt == 2'd0));

    p_flow_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((issue_cnt != 2'd0) && (s0_dst != '0)) |=>
        (!s0_valid || (s0_src_a != $past(s0_dst)) || (issue_cnt == 2'd0)));

    p_clean_group_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt == 2'd2) |-> (stall_why == 3'd0));

    p_stall_named_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && issue_cnt == 2'd0) |-> (stall_why != 3'd0));

    p_code_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall_why <= 3'd5);

endmodule

bind hz_dual_issue_checker hz_dual_issue_sva #(.NREGS(NREGS), .NUNITS(NUNITS)) u_sva (.*);

// File: tb/hz_dual_issue_checker_tb_top.sv
// Bench: driver task computes expected results from a private model of
// the requirements and pushes them into queues; a monitor pops and
// compares them against the design a few ns after each falling edge.
module hz_dual_issue_checker_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        bit       v;
        bit [4:0] d;
        bit [4:0] a;
        bit [4:0] b;
        bit [1:0] u;
        bit       br;
    } ins_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s0_valid = 0, s0_is_br = 0, s1_valid = 0;
    logic [4:0] s0_dst = 0, s0_src_a = 0, s0_src_b = 0;
    logic [4:0] s1_dst = 0, s1_src_a = 0, s1_src_b = 0;
    logic [1:0] s0_unit = 0, s1_unit = 0;
    logic [3:0] unit_busy = 0;
    logic       br_pending = 0, wb_valid = 0;
    logic [4:0] wb_reg = 0;
    logic [1:0] issue_cnt;
    logic [2:0] stall_why;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    pend_m [32];
    int    q_cnt [$];
    int    q_why [$];
    string q_tag [$];
    bit    finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hz_dual_issue_checker dut_i (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(s0_valid), .s0_dst(s0_dst), .s0_src_a(s0_src_a),
        .s0_src_b(s0_src_b), .s0_unit(s0_unit), .s0_is_br(s0_is_br),
        .s1_valid(s1_valid), .s1_dst(s1_dst), .s1_src_a(s1_src_a),
        .s1_src_b(s1_src_b), .s1_unit(s1_unit),
        .unit_busy(unit_busy), .br_pending(br_pending),
        .wb_valid(wb_valid), .wb_reg(wb_reg),
        .issue_cnt(issue_cnt), .stall_why(stall_why)
    );

    function automatic ins_t mk(bit v, int d, int a, int b, int u, bit br);
        ins_t t;
        t.v = v; t.d = 5'(d); t.a = 5'(a); t.b = 5'(b); t.u = 2'(u); t.br = br;
        return t;
    endfunction

    // Reason for one slot per R3..R7, R9, in R10 priority order
    function automatic int why_of(ins_t s, ins_t o, bit young, bit [3:0] busy, bit brp);
        bit ol = young && o.v;
        if (!s.v) return 0;
        if (brp || (ol && o.br)) return 1;
        if (busy[s.u] || (ol && o.u == s.u)) return 2;
        if ((s.a != 0 && (pend_m[s.a] || (ol && o.d == s.a))) ||
            (s.b != 0 && (pend_m[s.b] || (ol && o.d == s.b)))) return 3;
        if (s.d != 0 && (pend_m[s.d] || (ol && o.d == s.d))) return 4;
        if (ol && s.d != 0 && (s.d == o.a || s.d == o.b)) return 5;
        return 0;
    endfunction

    task automatic drive(ins_t i0, ins_t i1, bit [3:0] busy, bit brp,
                         bit wbv, int wbr, string tag);
        int w, cnt, why;
        @(negedge clk);
        s0_valid = i0.v; s0_dst = i0.d; s0_src_a = i0.a; s0_src_b = i0.b;
        s0_unit = i0.u; s0_is_br = i0.br;
        s1_valid = i1.v; s1_dst = i1.d; s1_src_a = i1.a; s1_src_b = i1.b;
        s1_unit = i1.u;
        unit_busy = busy; br_pending = brp; wb_valid = wbv; wb_reg = 5'(wbr);
        w = why_of(i0, i1, 1'b0, busy, brp);
        if (!i0.v)        begin cnt = 0; why = 0; end
        else if (w != 0)  begin cnt = 0; why = w; end
        else if (!i1.v)   begin cnt = 1; why = 0; end
        else begin
            w = why_of(i1, i0, 1'b1, busy, brp);
            cnt = (w != 0) ? 1 : 2;
            why = w;
        end
        q_cnt.push_back(cnt); q_why.push_back(why); q_tag.push_back(tag);
        // Model update at the coming edge (R8: set wins over clear)
        if (wbv) pend_m[wbr] = 1'b0;
        if (cnt >= 1 && i0.d != 0) pend_m[i0.d] = 1'b1;
        if (cnt == 2 && i1.d != 0) pend_m[i1.d] = 1'b1;
        pend_m[0] = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0; s0_valid = 0; s1_valid = 0; wb_valid = 0;
        br_pending = 0; unit_busy = 0;
        foreach (pend_m[k]) pend_m[k] = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare design outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (q_cnt.size() > 0) begin
                int ec, ew;
                string tg;
                ec = q_cnt.pop_front(); ew = q_why.pop_front(); tg = q_tag.pop_front();
                n_checks++;
                if (int'(issue_cnt) != ec) begin
                    n_fail++;
                    $display("FAIL %s issue_cnt actual=%0d expected=%0d", tg, issue_cnt, ec);
                end
                n_checks++;
                if (int'(stall_why) != ew) begin
                    n_fail++;
                    $display("FAIL %s stall_why actual=%0d expected=%0d", tg, stall_why, ew);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        ins_t nop;
        nop = mk(0, 0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R10: nothing offered
        drive(nop, nop, 0, 0, 0, 0, "R10 idle");
        // R2: two independent instructions issue together
        drive(mk(1, 1, 2, 3, 0, 0), mk(1, 4, 5, 6, 1, 0), 0, 0, 0, 0, "R2 pair");
        // R3: read of pending r1
        drive(mk(1, 7, 1, 0, 0, 0), nop, 0, 0, 0, 0, "R3 pending src");
        // R8: writeback r1 not yet visible this cycle
        drive(mk(1, 7, 0, 1, 0, 0), nop, 0, 0, 1, 1, "R8 wb latency");
        // R8: r1 released now; slot 0 issues alone, writeback r4
        drive(mk(1, 8, 1, 0, 0, 0), nop, 0, 0, 1, 4, "R8 wb release");
        // R4: write to pending r8
        drive(mk(1, 8, 0, 0, 1, 0), nop, 0, 0, 0, 0, "R4 pending dst");
        // R3: same-cycle flow
        drive(mk(1, 10, 0, 0, 0, 0), mk(1, 11, 10, 0, 1, 0), 0, 0, 0, 0, "R3 same cycle");
        // R4: same-cycle output
        drive(mk(1, 12, 0, 0, 0, 0), mk(1, 12, 0, 0, 1, 0), 0, 0, 0, 0, "R4 same cycle");
        // R5: younger overwrites older source
        drive(mk(1, 13, 14, 15, 0, 0), mk(1, 15, 16, 16, 1, 0), 0, 0, 0, 0, "R5 anti");
        // R6: same unit in one cycle
        drive(mk(1, 17, 0, 0, 2, 0), mk(1, 18, 0, 0, 2, 0), 0, 0, 0, 0, "R6 shared unit");
        // R6: busy unit
        drive(mk(1, 19, 0, 0, 1, 0), nop, 4'b0010, 0, 0, 0, "R6 busy unit");
        // R7: unresolved branch holds everything
        drive(mk(1, 19, 0, 0, 0, 0), mk(1, 20, 0, 0, 1, 0), 0, 1, 0, 0, "R7 br_pending");
        // R7: older slot is a branch
        drive(mk(1, 0, 2, 0, 3, 1), mk(1, 20, 0, 0, 0, 0), 0, 0, 0, 0, "R7 older branch");
        // R10: resource outranks flow (r8 pending, unit 0 busy)
        drive(mk(1, 21, 8, 0, 0, 0), nop, 4'b0001, 0, 0, 0, "R10 res over flow");
        // R10: procedural outranks resource
        drive(mk(1, 21, 8, 0, 0, 0), nop, 4'b0001, 1, 0, 0, "R10 proc over res");
        // R2: clean younger stays behind stalled older
        drive(mk(1, 22, 8, 0, 0, 0), mk(1, 23, 0, 0, 1, 0), 0, 0, 0, 0, "R2 in order");
        // R2: older invalid, younger valid
        drive(nop, mk(1, 23, 0, 0, 1, 0), 0, 0, 0, 0, "R2 older empty");
        // R9: register 0 everywhere
        drive(mk(1, 0, 0, 0, 0, 0), mk(1, 0, 0, 0, 1, 0), 0, 0, 0, 0, "R9 zero reg");
        drive(mk(1, 0, 0, 0, 2, 0), mk(1, 24, 0, 0, 3, 0), 0, 0, 0, 0, "R9 zero not pending");
        // R8: issue and writeback of r25 in one cycle; set wins
        drive(mk(1, 25, 0, 0, 0, 0), nop, 0, 0, 1, 25, "R8 set wins");
        drive(mk(1, 26, 25, 0, 0, 0), nop, 0, 0, 0, 0, "R8 set wins read");
        // R1: reset releases pending r8, r10, r12, r25
        pulse_reset();
        drive(mk(1, 8, 25, 10, 0, 0), mk(1, 12, 8, 0, 1, 0), 0, 0, 0, 0, "R1 after reset");
        drive(nop, nop, 0, 0, 0, 0, "R10 idle tail");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule